// File: doc/BRIEF.md
# Dual-Channel Buffer DMA Address Generator

This block produces buffer-memory addresses for two DMA engines that share a single local memory bus. The local channel moves packet bursts between a packet FIFO and buffer memory. The remote channel serves a host through a bidirectional I/O port. It acts as a slave and supplies only the buffer-side address; the host provides its own addressing. Each channel is loaded with a start address and a byte count. Each channel then raises a request for every transfer it wants. A fixed-priority arbiter grants at most one channel per cycle and drives the address of that channel onto the memory bus. Transfers of the two channels may interleave.

A configuration bit sets the data width to 8 or 16 bits. A second bit merges the channels into one 32-bit address. The remote channel's loaded start address then acts as a static upper half, which selects a 64 KB page. The local counter runs as the lower half and wraps within that page.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is high, and after it until a channel is started with a nonzero count, all outputs are 0 and no grant is given, even with requests high.
- R2: With cfg_wide=0 and cfg_combined=0, each granted transfer places the channel's current address on mem_addr[15:0], with mem_addr[31:16]=0. The channel's address then increases by 1. The first transfer uses the programmed start address.
- R3: With cfg_wide=1, each transfer advances the channel address by 2 and lowers the remaining count by 2. A count that is odd still ends after its final transfer.
- R4: With cfg_combined=1, a local transfer drives mem_addr = {remote loaded start address, local address}.
- R5: In combined mode, the lower 16 bits wrap from 0xFFFF (or 0xFFFE when wide) to 0x0000, and the upper half does not change.
- R6: In combined mode, remote requests are never granted.
- R7: A request sampled at a rising edge yields its grant and address after that same edge. At most one of loc_gnt and rem_gnt is high. mem_valid equals their OR, and mem_addr is 0 when mem_valid is low.
- R8: When both channels can transfer and no remote slot is open, the local channel is granted.
- R9: A local burst lasts up to BURST_LEN consecutive grants. While the local channel keeps requesting and has count left, the burst is not interrupted.
- R10: In the cycle after a local burst ends, a ready remote channel gets the grant, even if the local channel is also requesting.
- R11: A channel stops being granted once its count is used up. Its done output pulses for one cycle, together with its final grant. A channel started with count 0 is never granted.
- R12: A start pulse reloads the channel's address and count, and takes precedence over a transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = 16-bit data (step 2), 0 = 8-bit (step 1) |
| cfg_combined | input | 1 | 1 = merged 32-bit address mode |
| loc_start | input | 1 | Load local channel address and count |
| loc_addr_init | input | 16 | Local start address |
| loc_cnt_init | input | 16 | Local byte count |
| loc_req | input | 1 | Local channel requests a transfer |
| loc_gnt | output | 1 | Local transfer granted this cycle |
| loc_done | output | 1 | Local count used up, with last grant |
| rem_start | input | 1 | Load remote channel address and count |
| rem_addr_init | input | 16 | Remote start address (page in combined mode) |
| rem_cnt_init | input | 16 | Remote byte count |
| rem_req | input | 1 | Remote channel requests a transfer |
| rem_gnt | output | 1 | Remote transfer granted this cycle |
| rem_done | output | 1 | Remote count used up, with last grant |
| mem_valid | output | 1 | An address is on mem_addr |
| mem_addr | output | 32 | Buffer memory address |

## Verification
Every result is one register stage away from its cause. The grants, mem_valid, mem_addr and the done pulses all change at the rising edge that samples the requests and start pulses. The bench drives inputs just after a falling edge and computes the expected outputs for the next edge from a behavioural model. It compares them at the following falling edge, so each check sits exactly one edge after its stimulus. A start pulse therefore affects the address seen at the second edge after it is driven. The model follows the same one-cycle rule.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_LOC  = 2'd1,
    PICK_REM  = 2'd2
  } pick_e;

  // bytes moved per transfer for the selected data width
  function automatic logic [1:0] xfer_step(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dma_ag_chan.sv
module dma_ag_chan
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_init,
  input  logic [CNT_W-1:0]  cnt_init,
  input  logic              wide,
  input  logic              advance,
  output logic              active,
  output logic              last,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  step_c;
  logic [ADDR_W-1:0] step_a;

  assign step_c = CNT_W'(xfer_step(wide));
  assign step_a = ADDR_W'(xfer_step(wide));
  assign active = (cnt_q != '0);
  assign last   = (cnt_q <= step_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= advance && last && !start;
      if (start) begin
        addr  <= addr_init;
        cnt_q <= cnt_init;
      end else if (advance) begin
        addr  <= addr + step_a;
        cnt_q <= last ? '0 : (cnt_q - step_c);
      end
    end
  end

  // R11
  done_follows_adv_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(advance));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !start) |=> (addr == ADDR_W'($past(addr) + $past(step_a))));

  // R12
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr == $past(addr_init)));

endmodule

// File: rtl/dma_ag_arb.sv
module dma_ag_arb
  import dma_ag_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  loc_want,
  input  logic  rem_want,
  input  logic  loc_last,
  output pick_e pick
);

  localparam int BEAT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat_q;
  logic              slot_q;
  logic              burst_end;

  always_comb begin
    if (slot_q && rem_want)  pick = PICK_REM;
    else if (loc_want)       pick = PICK_LOC;
    else if (rem_want)       pick = PICK_REM;
    else                     pick = PICK_NONE;
  end

  assign burst_end = (pick == PICK_LOC) && ((beat_q == LAST_BEAT) || loc_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      slot_q <= 1'b0;
    end else begin
      slot_q <= burst_end;
      if (pick == PICK_LOC) beat_q <= burst_end ? '0 : (beat_q + BEAT_W'(1));
      else                  beat_q <= '0;
    end
  end

  // R9
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pick == PICK_LOC) && !$past(burst_end) && loc_want) |-> (pick == PICK_LOC));

  // R10
  rem_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(burst_end) && rem_want) |-> (pick == PICK_REM));

  // R8
  loc_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (loc_want && rem_want && !$past(burst_end)) |-> (pick == PICK_LOC));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wide,
  input  logic                  cfg_combined,
  input  logic                  loc_start,
  input  logic [ADDR_W-1:0]     loc_addr_init,
  input  logic [CNT_W-1:0]      loc_cnt_init,
  input  logic                  loc_req,
  output logic                  loc_gnt,
  output logic                  loc_done,
  input  logic                  rem_start,
  input  logic [ADDR_W-1:0]     rem_addr_init,
  input  logic [CNT_W-1:0]      rem_cnt_init,
  input  logic                  rem_req,
  output logic                  rem_gnt,
  output logic                  rem_done,
  output logic                  mem_valid,
  output logic [2*ADDR_W-1:0]   mem_addr
);

  localparam int NCH  = 2;
  localparam int BUSW = 2 * ADDR_W;

  logic [NCH-1:0]    start_v, adv_v, act_v, last_v, done_v;
  logic [ADDR_W-1:0] ainit_v [NCH];
  logic [CNT_W-1:0]  cinit_v [NCH];
  logic [ADDR_W-1:0] addr_v  [NCH];
  logic              loc_want, rem_want;
  pick_e             pick;
  logic [BUSW-1:0]   addr_next;

  assign start_v    = {rem_start, loc_start};
  assign ainit_v[0] = loc_addr_init;
  assign ainit_v[1] = rem_addr_init;
  assign cinit_v[0] = loc_cnt_init;
  assign cinit_v[1] = rem_cnt_init;
  assign adv_v      = {pick == PICK_REM, pick == PICK_LOC};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_ag_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .start     (start_v[g]),
      .addr_init (ainit_v[g]),
      .cnt_init  (cinit_v[g]),
      .wide      (cfg_wide),
      .advance   (adv_v[g]),
      .active    (act_v[g]),
      .last      (last_v[g]),
      .addr      (addr_v[g]),
      .done      (done_v[g])
    );
  end

  assign loc_want = loc_req && act_v[0];
  assign rem_want = rem_req && act_v[1] && !cfg_combined;

  dma_ag_arb #(.BURST_LEN(BURST_LEN)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .loc_want (loc_want),
    .rem_want (rem_want),
    .loc_last (last_v[0]),
    .pick     (pick)
  );

  always_comb begin
    unique case (pick)
      PICK_LOC: addr_next = cfg_combined ? {addr_v[1], addr_v[0]}
                                         : {{ADDR_W{1'b0}}, addr_v[0]};
      PICK_REM: addr_next = {{ADDR_W{1'b0}}, addr_v[1]};
      default:  addr_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_gnt   <= 1'b0;
      rem_gnt   <= 1'b0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
    end else begin
      loc_gnt   <= (pick == PICK_LOC);
      rem_gnt   <= (pick == PICK_REM);
      mem_valid <= (pick != PICK_NONE);
      mem_addr  <= addr_next;
    end
  end

  assign loc_done = done_v[0];
  assign rem_done = done_v[1];

  // R7
  one_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loc_gnt, rem_gnt}));

  // R7
  valid_match_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid == (loc_gnt || rem_gnt));

  // R6
  comb_no_rem_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_combined) |-> !rem_gnt);

  // R11
  loc_done_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    loc_done |-> loc_gnt);

  // R11
  rem_done_due_chk: assert property (@(posedge clk) disable iff (rst)
    (pick == PICK_REM && last_v[1] && !rem_start) |=> rem_done);

endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;

  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0, cfg_combined = 1'b0;
  logic        loc_start = 1'b0, rem_start = 1'b0;
  logic [15:0] loc_addr_init = '0, rem_addr_init = '0;
  logic [15:0] loc_cnt_init = '0, rem_cnt_init = '0;
  logic        loc_req = 1'b0, rem_req = 1'b0;
  logic        loc_gnt, loc_done, rem_gnt, rem_done, mem_valid;
  logic [31:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model state
  logic [15:0] m_laddr, m_raddr;
  int m_lcnt, m_rcnt, m_beat;
  bit m_slot;
  bit e_lg, e_rg, e_valid, e_ld, e_rd;
  logic [31:0] e_addr;

  always #2 clk = ~clk;

  dma_addr_gen u_dut (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_combined(cfg_combined),
    .loc_start(loc_start), .loc_addr_init(loc_addr_init), .loc_cnt_init(loc_cnt_init),
    .loc_req(loc_req), .loc_gnt(loc_gnt), .loc_done(loc_done),
    .rem_start(rem_start), .rem_addr_init(rem_addr_init), .rem_cnt_init(rem_cnt_init),
    .rem_req(rem_req), .rem_gnt(rem_gnt), .rem_done(rem_done),
    .mem_valid(mem_valid), .mem_addr(mem_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // predict the next edge from current inputs, then compare at the falling edge
  task automatic tick();
    int  step;
    bit  lw, rw, pl, pr, lastl, lastr, bend;
    if (rst) begin
      m_laddr = '0; m_raddr = '0; m_lcnt = 0; m_rcnt = 0; m_beat = 0; m_slot = 0;
      e_lg = 0; e_rg = 0; e_valid = 0; e_ld = 0; e_rd = 0; e_addr = '0;
    end else begin
      step  = cfg_wide ? 2 : 1;
      lw    = loc_req && (m_lcnt != 0);
      rw    = rem_req && (m_rcnt != 0) && !cfg_combined;
      pl    = 0; pr = 0;
      if (m_slot && rw) pr = 1;
      else if (lw)      pl = 1;
      else if (rw)      pr = 1;
      lastl = (m_lcnt <= step);
      lastr = (m_rcnt <= step);
      e_lg = pl; e_rg = pr; e_valid = pl | pr;
      if (pl)      e_addr = cfg_combined ? {m_raddr, m_laddr} : {16'h0, m_laddr};
      else if (pr) e_addr = {16'h0, m_raddr};
      else         e_addr = '0;
      e_ld = pl && lastl && !loc_start;
      e_rd = pr && lastr && !rem_start;
      bend   = pl && ((m_beat == BL - 1) || lastl);
      m_beat = pl ? (bend ? 0 : m_beat + 1) : 0;
      m_slot = bend;
      if (loc_start) begin m_laddr = loc_addr_init; m_lcnt = int'(loc_cnt_init); end
      else if (pl) begin m_laddr = m_laddr + 16'(step); m_lcnt = lastl ? 0 : m_lcnt - step; end
      if (rem_start) begin m_raddr = rem_addr_init; m_rcnt = int'(rem_cnt_init); end
      else if (pr) begin m_raddr = m_raddr + 16'(step); m_rcnt = lastr ? 0 : m_rcnt - step; end
    end
    @(negedge clk);
    chk("R6 R8 R9 R10 R11 loc_gnt", {31'b0, loc_gnt}, {31'b0, e_lg});
    chk("R6 R8 R9 R10 R11 rem_gnt", {31'b0, rem_gnt}, {31'b0, e_rg});
    chk("R7 mem_valid", {31'b0, mem_valid}, {31'b0, e_valid});
    chk("R2 R3 R4 R5 R12 mem_addr", mem_addr, e_addr);
    chk("R11 loc_done", {31'b0, loc_done}, {31'b0, e_ld});
    chk("R11 rem_done", {31'b0, rem_done}, {31'b0, e_rd});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load(input bit do_l, input logic [15:0] la, input logic [15:0] lc,
                      input bit do_r, input logic [15:0] ra, input logic [15:0] rc);
    loc_start = do_l; loc_addr_init = la; loc_cnt_init = lc;
    rem_start = do_r; rem_addr_init = ra; rem_cnt_init = rc;
    tick();
    loc_start = 1'b0; rem_start = 1'b0;
  endtask

  initial begin
    // R1: reset with requests high
    loc_req = 1'b1; rem_req = 1'b1;
    run(4);
    rst = 1'b0;
    run(3);
    chk("R1 idle after reset", {loc_gnt, rem_gnt, mem_valid, loc_done, rem_done}, 5'b0);
    chk("R1 addr after reset", mem_addr, 32'h0);

    // R2 R8 R9 R10: 8-bit, both channels busy
    loc_req = 1'b0; rem_req = 1'b0;
    load(1, 16'h0100, 16'd10, 1, 16'h0800, 16'd3);
    loc_req = 1'b1; rem_req = 1'b1;
    run(20);

    // R3 R9: 16-bit with an odd count and a local drop mid-burst
    loc_req = 1'b0; rem_req = 1'b0;
    cfg_wide = 1'b1;
    load(1, 16'h2000, 16'd13, 1, 16'h3000, 16'd6);
    loc_req = 1'b1; rem_req = 1'b1;
    run(2);
    loc_req = 1'b0;
    run(2);
    loc_req = 1'b1;
    run(14);

    // R4 R5 R6: combined mode with wrap, 8-bit
    loc_req = 1'b0; rem_req = 1'b0;
    cfg_wide = 1'b0; cfg_combined = 1'b1;
    load(1, 16'hFFFE, 16'd5, 1, 16'h0003, 16'd8);
    loc_req = 1'b1; rem_req = 1'b1;
    run(9);

    // R5: combined, 16-bit wrap
    loc_req = 1'b0;
    cfg_wide = 1'b1;
    load(1, 16'hFFFC, 16'd8, 1, 16'h00A5, 16'd2);
    loc_req = 1'b1;
    run(7);

    // R11: zero count never granted
    loc_req = 1'b0; rem_req = 1'b0;
    cfg_wide = 1'b0; cfg_combined = 1'b0;
    load(1, 16'h4444, 16'd0, 1, 16'h5555, 16'd0);
    loc_req = 1'b1; rem_req = 1'b1;
    run(4);
    chk("R11 zero count", {31'b0, mem_valid}, 32'h0);

    // R12: reload while transferring
    load(1, 16'h0040, 16'd20, 0, 16'h0, 16'd0);
    run(3);
    load(1, 16'h0500, 16'd2, 1, 16'h0900, 16'd1);
    run(6);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule